// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Hub

This block holds the inter-processor interrupt state for every core of a multi-core cluster. Each core owns a 32-bit pending-status word, a 32-bit enable word and one interrupt output. Any agent may issue a send command that names a destination core and one action bit. That bit is merged into the destination's pending word. The destination's interrupt line goes high when its pending word leaves all-zero.

Each core uses the register port to read its own words, to rewrite its enable word and to acknowledge pending bits with a write-one-to-clear access. The interrupt line drops only when such an acknowledge leaves the pending word empty. The enable word is plain storage and does not gate the interrupt line. Direct writes to the pending word are refused with an error. A send aimed at a core that does not exist is dropped and flagged.

Top module: `ipi_hub`

## Requirements
- R1: After reset every pending word and enable word reads 0, every irq bit is 0, and send_err, reg_rvalid and reg_err are 0.
- R2: A send with send_valid high targets core send_data[25:16] and ORs bit send_data[4:0] into that core's pending word. Bits already set stay set. Other cores are untouched. Bits 31:26 and 15:5 of send_data are ignored.
- R3: irq[c] rises in the cycle after a send to core c whose pending word was zero. A further send to a core that is already pending leaves irq[c] high.
- R4: A write to selector 3 (clear) clears the pending bits that are 1 in reg_wdata. irq[c] falls in the next cycle only if the pending word becomes zero; otherwise it stays high.
- R5: A send whose target field is NUM_CORES or more changes no pending word and no irq bit, and it raises send_err for exactly the next cycle.
- R6: A write to selector 0 (pending word) or selector 2 (set) sets reg_err with its response and leaves all state unchanged.
- R7: Selector 1 (enable) reads back the last full 32-bit value written to it, and writing it never changes irq.
- R8: Reads of selector 2 and selector 3 return 0 whatever the pending word holds.
- R9: When a send and a clear write reach the same core in one cycle, the clear is applied first and the set second. irq reflects the resulting pending word.
- R10: reg_rvalid is high exactly one cycle after each cycle with reg_valid high. reg_rdata then holds the value from before that cycle's updates, so a read issued together with a send returns the old word.
- R11: An access with reg_core of NUM_CORES or more returns reg_err with reg_rdata 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_valid | input | 1 | Send command strobe |
| send_data | input | DATA_W | Send command: target core in 25:16, action bit index in 4:0 |
| send_err | output | 1 | Pulses one cycle after a send to a nonexistent core |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_core | input | 10 | Core whose registers are accessed |
| reg_sel | input | 2 | 0 pending, 1 enable, 2 set, 3 clear |
| reg_wdata | input | DATA_W | Write data |
| reg_rvalid | output | 1 | Response strobe, one cycle after reg_valid |
| reg_rdata | output | DATA_W | Read data for the response |
| reg_err | output | 1 | Access refused |
| irq | output | NUM_CORES | One interrupt line per core |

## Verification
Sends, clears and enable writes land on the next rising edge. The irq bits and send_err therefore change one cycle after the stimulus, and register responses also appear one cycle after reg_valid. Every bench task drives its inputs after a falling edge, waits for one rising edge, and samples on the following falling edge. Readback of the pending word is a separate access issued after the update. This timing lets the check on a read issued together with a send prove that the old value is returned.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CORE_ID_W   = 10;
  localparam int CORE_ID_LSB = 16;

  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_SET   = 2'd2,
    SEL_CLEAR = 2'd3
  } ipi_sel_e;
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ipi_send_decode.sv
module ipi_send_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 send_valid,
  input  logic [DATA_W-1:0]    send_data,
  output logic [NUM_CORES-1:0] hit,
  output logic [DATA_W-1:0]    set_mask,
  output logic                 err_q
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [CORE_ID_W-1:0] target;
  logic                 target_bad;
  logic                 err_d;
  logic                 unused_fields;

  assign target        = send_data[CORE_ID_LSB +: CORE_ID_W];
  assign target_bad    = (target >= CORE_ID_W'(NUM_CORES));
  assign set_mask      = DATA_W'(1) << send_data[IDX_W-1:0];
  assign unused_fields = ^{send_data[DATA_W-1:CORE_ID_LSB+CORE_ID_W],
                           send_data[CORE_ID_LSB-1:IDX_W]};

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_hit
    assign hit[c] = send_valid && (target == CORE_ID_W'(c));
  end

  always_comb begin
    err_d = send_valid && target_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/ipi_core_slice.sv
module ipi_core_slice #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_hit,
  input  logic [DATA_W-1:0] set_mask,
  input  logic              clr_we,
  input  logic              en_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] enable_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] after_clr;
  logic [DATA_W-1:0] status_d;
  logic [DATA_W-1:0] enable_d;
  logic              status_ce;
  logic              irq_d;
  logic              irq_ce;

  always_comb begin
    clr_mask  = clr_we ? wdata : '0;
    after_clr = status_q & ~clr_mask;
    status_d  = after_clr | (set_hit ? set_mask : '0);
    status_ce = set_hit | clr_we;
    enable_d  = wdata;
    irq_ce    = set_hit | clr_we;
    irq_d     = irq_q;
    if (set_hit) begin
      if (after_clr == '0) begin
        irq_d = 1'b1;
      end
    end else if (clr_we && (after_clr == '0)) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (status_ce) status_q <= status_d;
      if (en_we)     enable_q <= enable_d;
      if (irq_ce)    irq_q    <= irq_d;
    end
  end
endmodule

// File: rtl/ipi_reg_port.sv
module ipi_reg_port
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_valid,
  input  logic                              reg_write,
  input  logic [CORE_ID_W-1:0]              reg_core,
  input  logic [1:0]                        reg_sel,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]  status_all,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]  enable_all,
  output logic [NUM_CORES-1:0]              clr_we,
  output logic [NUM_CORES-1:0]              en_we,
  output logic                              rvalid_q,
  output logic [DATA_W-1:0]                 rdata_q,
  output logic                              err_q
);
  ipi_sel_e          sel;
  logic              core_ok;
  logic              refuse;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_d;
  logic              err_d;

  assign sel     = ipi_sel_e'(reg_sel);
  assign core_ok = (reg_core < CORE_ID_W'(NUM_CORES));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_we
    assign clr_we[c] = reg_valid && reg_write && (sel == SEL_CLEAR) &&
                       (reg_core == CORE_ID_W'(c));
    assign en_we[c]  = reg_valid && reg_write && (sel == SEL_MASK) &&
                       (reg_core == CORE_ID_W'(c));
  end

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (reg_core == CORE_ID_W'(c)) begin
        case (sel)
          SEL_PEND: rd_val = status_all[c];
          SEL_MASK: rd_val = enable_all[c];
          default:  rd_val = '0;
        endcase
      end
    end
    refuse  = !core_ok ||
              (reg_write && ((sel == SEL_PEND) || (sel == SEL_SET)));
    rdata_d = (reg_write || !core_ok) ? '0 : rd_val;
    err_d   = refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= reg_valid;
      if (reg_valid) begin
        rdata_q <= rdata_d;
        err_q   <= err_d;
      end else begin
        err_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 send_valid,
  input  logic [DATA_W-1:0]    send_data,
  output logic                 send_err,
  input  logic                 reg_valid,
  input  logic                 reg_write,
  input  logic [9:0]           reg_core,
  input  logic [1:0]           reg_sel,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic                 reg_rvalid,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 reg_err,
  output logic [NUM_CORES-1:0] irq
);
  logic                             rst_core_n;
  logic [NUM_CORES-1:0]             hit;
  logic [DATA_W-1:0]                set_mask;
  logic [NUM_CORES-1:0]             clr_we;
  logic [NUM_CORES-1:0]             en_we;
  logic [NUM_CORES-1:0][DATA_W-1:0] status_all;
  logic [NUM_CORES-1:0][DATA_W-1:0] enable_all;

  ipi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ipi_send_decode #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .send_valid (send_valid),
    .send_data  (send_data),
    .hit        (hit),
    .set_mask   (set_mask),
    .err_q      (send_err)
  );

  ipi_reg_port #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_core   (reg_core),
    .reg_sel    (reg_sel),
    .status_all (status_all),
    .enable_all (enable_all),
    .clr_we     (clr_we),
    .en_we      (en_we),
    .rvalid_q   (reg_rvalid),
    .rdata_q    (reg_rdata),
    .err_q      (reg_err)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_core_slice #(.DATA_W(DATA_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .set_hit  (hit[c]),
      .set_mask (set_mask),
      .clr_we   (clr_we[c]),
      .en_we    (en_we[c]),
      .wdata    (reg_wdata),
      .status_q (status_all[c]),
      .enable_q (enable_all[c]),
      .irq_q    (irq[c])
    );
  end
endmodule

// File: rtl/ipi_hub_chk.sv
module ipi_hub_chk #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 send_valid,
  input logic [DATA_W-1:0]    send_data,
  input logic                 send_err,
  input logic                 reg_valid,
  input logic                 reg_write,
  input logic [9:0]           reg_core,
  input logic [1:0]           reg_sel,
  input logic                 reg_rvalid,
  input logic [DATA_W-1:0]    reg_rdata,
  input logic                 reg_err,
  input logic [NUM_CORES-1:0] irq
);
  logic [9:0] tgt;
  logic       unused_chk;
  assign tgt        = send_data[25:16];
  assign unused_chk = ^{send_data[DATA_W-1:26], send_data[15:0]};

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
    a_r3_irq_after_send: assert property (@(posedge clk) disable iff (!rst_n)
      (send_valid && (tgt == 10'(c))) |=> irq[c]);
  end

  a_r5_bad_target_err: assert property (@(posedge clk) disable iff (!rst_n)
    (send_valid && (tgt >= 10'(NUM_CORES))) |=> send_err);

  a_r5_err_needs_send: assert property (@(posedge clk) disable iff (!rst_n)
    !send_valid |=> !send_err);

  a_r6_pend_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && (reg_sel == 2'd0)) |=> (reg_rvalid && reg_err));

  a_r8_set_clear_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_sel[1]) |=> (reg_rdata == '0));

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_valid && !(reg_valid && reg_write)) |=> $stable(irq));

  a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |=> reg_rvalid);

  a_r10_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_valid |=> !reg_rvalid);

  a_r11_bad_core_err: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && (reg_core >= 10'(NUM_CORES))) |=> (reg_err && (reg_rdata == '0)));
endmodule

bind ipi_hub ipi_hub_chk #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .send_valid (send_valid),
  .send_data  (send_data),
  .send_err   (send_err),
  .reg_valid  (reg_valid),
  .reg_write  (reg_write),
  .reg_core   (reg_core),
  .reg_sel    (reg_sel),
  .reg_rvalid (reg_rvalid),
  .reg_rdata  (reg_rdata),
  .reg_err    (reg_err),
  .irq        (irq)
);

// File: tb/test_ipi_hub.sv
module test_ipi_hub;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          send_valid = 1'b0;
  logic [31:0]   send_data = '0;
  logic          send_err;
  logic          reg_valid = 1'b0;
  logic          reg_write = 1'b0;
  logic [9:0]    reg_core = '0;
  logic [1:0]    reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_rvalid;
  logic [31:0]   reg_rdata;
  logic          reg_err;
  logic [NC-1:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ipi_hub #(.NUM_CORES(NC), .DATA_W(32)) i_ipi_hub (
    .clk(clk), .rst_n(rst_n),
    .send_valid(send_valid), .send_data(send_data), .send_err(send_err),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_core(reg_core),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input int core, input int bitn);
    return (32'(core) << 16) | 32'(bitn);
  endfunction

  task automatic idle_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] d);
    send_valid = 1'b1;
    send_data  = d;
    @(posedge clk);
    @(negedge clk);
    send_valid = 1'b0;
    send_data  = '0;
  endtask

  task automatic access(input logic wr, input int core, input int sel, input logic [31:0] wd);
    reg_valid = 1'b1;
    reg_write = wr;
    reg_core  = 10'(core);
    reg_sel   = 2'(sel);
    reg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    reg_valid = 1'b0;
    reg_write = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic rd(input int core, input int sel, output logic [31:0] v);
    access(1'b0, core, sel, '0);
    v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 send_err", 32'(send_err), 32'h0);
    chk("R1 rvalid", 32'(reg_rvalid), 32'h0);
    for (int c = 0; c < NC; c++) begin
      rd(c, 0, v); chk("R1 pending", v, 32'h0);
      rd(c, 1, v); chk("R1 enable", v, 32'h0);
    end
  endtask

  task automatic t_send_basic();
    logic [31:0] v;
    send(32'hFC00_FFE0 & 32'hFC00_FFE0 | cmd(2, 5));
    chk("R3 irq rises core2", 32'(irq), 32'h4);
    chk("R2 no send_err", 32'(send_err), 32'h0);
    rd(2, 0, v); chk("R2 pending core2 bit5", v, 32'h0000_0020);
    rd(1, 0, v); chk("R2 other core untouched", v, 32'h0);
    send(cmd(2, 5));
    send(cmd(2, 31));
    chk("R3 irq stays high", 32'(irq), 32'h4);
    rd(2, 0, v); chk("R2 OR accumulate", v, 32'h8000_0020);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    access(1'b1, 2, 3, 32'h0000_0020);
    chk("R4 irq held partial clear", 32'(irq), 32'h4);
    rd(2, 0, v); chk("R4 partial clear", v, 32'h8000_0000);
    access(1'b1, 2, 3, 32'h8000_0001);
    chk("R4 irq falls at zero", 32'(irq), 32'h0);
    rd(2, 0, v); chk("R4 pending empty", v, 32'h0);
  endtask

  task automatic t_bad_target();
    logic [31:0] v;
    send(cmd(7, 3));
    chk("R5 send_err pulse", 32'(send_err), 32'h1);
    chk("R5 irq unchanged", 32'(irq), 32'h0);
    idle_cycle();
    chk("R5 send_err one cycle", 32'(send_err), 32'h0);
    send(cmd(10'h3FF, 0) | 32'h0000_0403);
    chk("R5 send_err max id", 32'(send_err), 32'h1);
    for (int c = 0; c < NC; c++) begin
      rd(c, 0, v); chk("R5 no pending change", v, 32'h0);
    end
  endtask

  task automatic t_refused();
    logic [31:0] v;
    access(1'b1, 1, 0, 32'hFFFF_FFFF);
    chk("R6 pend write err", 32'(reg_err), 32'h1);
    chk("R6 irq unchanged", 32'(irq), 32'h0);
    rd(1, 0, v); chk("R6 pending unchanged", v, 32'h0);
    chk("R6 read no err", 32'(reg_err), 32'h0);
    access(1'b1, 1, 2, 32'h0000_0010);
    chk("R6 set write err", 32'(reg_err), 32'h1);
    rd(1, 0, v); chk("R6 set write no effect", v, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    access(1'b1, 3, 1, 32'hA5A5_5A5A);
    chk("R7 irq not gated", 32'(irq), 32'h0);
    chk("R7 write ok", 32'(reg_err), 32'h0);
    rd(3, 1, v); chk("R7 enable readback", v, 32'hA5A5_5A5A);
    rd(2, 1, v); chk("R7 other enable", v, 32'h0);
    send(cmd(3, 9));
    access(1'b1, 3, 1, 32'h0);
    chk("R7 enable clear keeps irq", 32'(irq), 32'h8);
  endtask

  task automatic t_zero_reads();
    logic [31:0] v;
    rd(3, 2, v); chk("R8 set reads 0", v, 32'h0);
    rd(3, 3, v); chk("R8 clear reads 0", v, 32'h0);
    rd(3, 0, v); chk("R8 pending still set", v, 32'h0000_0200);
    access(1'b1, 3, 3, 32'hFFFF_FFFF);
    chk("R4 full clear drops irq", 32'(irq), 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    send(cmd(0, 1));
    send_valid = 1'b1; send_data = cmd(0, 1);
    access(1'b1, 0, 3, 32'h0000_0002);
    send_valid = 1'b0; send_data = '0;
    chk("R9 clear then set keeps irq", 32'(irq), 32'h1);
    rd(0, 0, v); chk("R9 bit restored", v, 32'h0000_0002);
    send_valid = 1'b1; send_data = cmd(0, 4);
    access(1'b1, 0, 3, 32'h0000_0002);
    send_valid = 1'b0; send_data = '0;
    chk("R9 irq after swap", 32'(irq), 32'h1);
    rd(0, 0, v); chk("R9 swapped bits", v, 32'h0000_0010);
    access(1'b1, 0, 3, 32'h0000_0010);
    chk("R9 cleanup irq", 32'(irq), 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    send_valid = 1'b1; send_data = cmd(1, 7);
    rd(1, 0, v);
    send_valid = 1'b0; send_data = '0;
    chk("R10 read sees old value", v, 32'h0);
    chk("R10 rvalid", 32'(reg_rvalid), 32'h1);
    idle_cycle();
    chk("R10 rvalid single", 32'(reg_rvalid), 32'h0);
    rd(1, 0, v); chk("R10 new value later", v, 32'h0000_0080);
  endtask

  task automatic t_bad_core();
    logic [31:0] v;
    access(1'b1, 9, 3, 32'hFFFF_FFFF);
    chk("R11 bad core err", 32'(reg_err), 32'h1);
    chk("R11 irq kept", 32'(irq), 32'h2);
    rd(9, 0, v);
    chk("R11 read err", 32'(reg_err), 32'h1);
    chk("R11 read data zero", v, 32'h0);
    rd(1, 0, v); chk("R11 pending kept", v, 32'h0000_0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_send_basic();
    t_clear();
    t_bad_target();
    t_refused();
    t_enable();
    t_zero_reads();
    t_same_cycle();
    t_timing();
    t_bad_core();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule